// File: doc/BRIEF.md
# Data Transfer Direction Tracker

This block follows the data phase of each card command and records whether data is currently coming in from the card or going out to it. The host's command interface raises one pulse when a command has been fully loaded. The pulse carries a transfer kind and the command index. The block answers with two direction flags: receive-active and transmit-active.

The host status word has one buffer-empty bit and one buffer-full bit. The block feeds these bits from whichever data buffer matters at the moment. While a receive is in progress they come from the receive buffer. At all other times they come from the transmit buffer.

In a single-block read, the receive flag stays up until two things have happened: the data phase (payload plus CRC16) has finished, and the host has drained the receive buffer. In a multi-block read, the flag stays up until a stop-transmission command is loaded, whatever the data phase reports.

Top module: `xfer_dir_tracker`

## Requirements
- R1: While `rst` is high, `rx_active` and `tx_active` read 0, `buf_empty` reads 1 and `buf_full` reads 0. After `rst` is released, both flags stay 0 until a command arrives.
- R2: A `cmd_start` pulse with `cmd_kind` = 2'b01 (single read) and an index other than the stop index raises `rx_active` at the next clock edge.
- R3: In a single read, `rx_active` falls at the first clock edge at which `rx_empty` is 1 and a `data_done` pulse has been seen, either in that cycle or earlier. Before that, `rx_active` stays high.
- R4: A `cmd_start` pulse with `cmd_kind` = 2'b11 (multi-block read) raises `rx_active`. The flag then ignores `data_done`, `rx_empty` and commands of kind 2'b00. It falls at the edge that samples a `cmd_start` whose `cmd_index` equals the stop index (default 12), whatever that command's kind.
- R5: While `rx_active` is 1 and no reset is applied, `buf_empty` equals `rx_empty` and `buf_full` equals `rx_full`.
- R6: While `rx_active` is 0 and no reset is applied, `buf_empty` equals `tx_empty` and `buf_full` equals `tx_full`.
- R7: A `cmd_start` with `cmd_kind` = 2'b10 (write) and an index other than the stop index raises `tx_active` at the next edge. At that same edge it clears any receive state.
- R8: A `cmd_complete` pulse with no `cmd_start` in the same cycle drops `tx_active` at the next edge.
- R9: `rx_active` and `tx_active` are never 1 at the same time.
- R10: While `sw_rst` is high, both flags read 0 and `buf_empty` reads 1 in that same cycle. The tracking state is cleared at the edge, so both flags remain 0 after `sw_rst` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous hardware reset, active high |
| sw_rst | input | 1 | Software reset, active high; masks the outputs at once |
| cmd_start | input | 1 | One-cycle pulse: command fully loaded |
| cmd_kind | input | 2 | 00 no data, 01 single read, 10 write, 11 multi-block read |
| cmd_index | input | 6 | Command index field of the loaded command |
| data_done | input | 1 | Pulse: receive data phase, including CRC16, finished |
| rx_empty | input | 1 | Receive buffer empty |
| rx_full | input | 1 | Receive buffer full |
| tx_empty | input | 1 | Transmit buffer empty |
| tx_full | input | 1 | Transmit buffer full |
| cmd_complete | input | 1 | Pulse: current command fully executed |
| rx_active | output | 1 | Data is being received from the card |
| tx_active | output | 1 | Data is being sent to the card |
| buf_empty | output | 1 | Buffer-empty bit for the status word |
| buf_full | output | 1 | Buffer-full bit for the status word |

## Verification
The two direction flags are registered, so their response to a stimulus is due one clock edge later. The bench drives every input on the falling edge and samples one falling edge after the rising edge that captures the input. The buffer bits and the software-reset mask are combinational. They are checked shortly after the input changes, inside the same cycle and before any clock edge. The negative cases are handled the same way: a `data_done` pulse while the buffer is still full, or a non-data command during a multi-block read, is sampled at the point where the flag would have fallen.

// File: rtl/xfer_dir_pkg.sv
package xfer_dir_pkg;

    typedef enum logic [1:0] {
        KIND_NODATA = 2'b00,
        KIND_READ   = 2'b01,
        KIND_WRITE  = 2'b10,
        KIND_MREAD  = 2'b11
    } xfer_kind_e;

    typedef struct packed {
        logic       start;
        logic       stop;
        xfer_kind_e kind;
    } cmd_evt_t;

    function automatic logic kind_is_read(input xfer_kind_e k);
        return (k == KIND_READ) || (k == KIND_MREAD);
    endfunction

endpackage

// File: rtl/rx_track.sv
module rx_track
    import xfer_dir_pkg::*;
(
    input  logic     clk,
    input  logic     clr,
    input  cmd_evt_t ev,
    input  logic     data_done,
    input  logic     rx_empty,
    output logic     rx_on
);
    logic rx_q, multi_q, done_q;
    logic rx_d, multi_d, done_d;

    always_comb begin
        rx_d    = rx_q;
        multi_d = multi_q;
        done_d  = done_q;
        if (ev.start && ev.stop) begin
            rx_d    = 1'b0;
            multi_d = 1'b0;
            done_d  = 1'b0;
        end else if (ev.start && kind_is_read(ev.kind)) begin
            rx_d    = 1'b1;
            multi_d = (ev.kind == KIND_MREAD);
            done_d  = 1'b0;
        end else if (ev.start && ev.kind == KIND_WRITE) begin
            rx_d    = 1'b0;
            multi_d = 1'b0;
            done_d  = 1'b0;
        end else if (rx_q && !multi_q) begin
            if ((done_q || data_done) && rx_empty) begin
                rx_d   = 1'b0;
                done_d = 1'b0;
            end else if (data_done) begin
                done_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            rx_q    <= 1'b0;
            multi_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            rx_q    <= rx_d;
            multi_q <= multi_d;
            done_q  <= done_d;
        end
    end

    assign rx_on = rx_q;

    assert_rd_start_R2: assert property (@(posedge clk) disable iff (clr)
        (ev.start && !ev.stop && kind_is_read(ev.kind)) |=> rx_q);

    assert_stop_clear_R4: assert property (@(posedge clk) disable iff (clr)
        (ev.start && ev.stop) |=> !rx_q);

    assert_multi_hold_R4: assert property (@(posedge clk) disable iff (clr)
        (rx_q && multi_q && !ev.start) |=> rx_q);

    assert_single_hold_R3: assert property (@(posedge clk) disable iff (clr)
        (rx_q && !multi_q && !ev.start && !rx_empty) |=> rx_q);

endmodule

// File: rtl/tx_track.sv
module tx_track
    import xfer_dir_pkg::*;
(
    input  logic     clk,
    input  logic     clr,
    input  cmd_evt_t ev,
    input  logic     cmd_complete,
    output logic     tx_on
);
    logic tx_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            tx_q <= 1'b0;
        end else if (ev.start && !ev.stop && ev.kind == KIND_WRITE) begin
            tx_q <= 1'b1;
        end else if (ev.start && !ev.stop && kind_is_read(ev.kind)) begin
            tx_q <= 1'b0;
        end else if (cmd_complete && !ev.start) begin
            tx_q <= 1'b0;
        end
    end

    assign tx_on = tx_q;

    assert_wr_start_R7: assert property (@(posedge clk) disable iff (clr)
        (ev.start && !ev.stop && ev.kind == KIND_WRITE) |=> tx_q);

    assert_complete_drop_R8: assert property (@(posedge clk) disable iff (clr)
        (cmd_complete && !ev.start) |=> !tx_q);

endmodule

// File: rtl/bufstat_mux.sv
module bufstat_mux (
    input  logic hold,
    input  logic sel_rx,
    input  logic rx_empty,
    input  logic rx_full,
    input  logic tx_empty,
    input  logic tx_full,
    output logic buf_empty,
    output logic buf_full
);
    always_comb begin
        if (hold) begin
            buf_empty = 1'b1;
            buf_full  = 1'b0;
        end else if (sel_rx) begin
            buf_empty = rx_empty;
            buf_full  = rx_full;
        end else begin
            buf_empty = tx_empty;
            buf_full  = tx_full;
        end
    end
endmodule

// File: rtl/xfer_dir_tracker.sv
module xfer_dir_tracker
    import xfer_dir_pkg::*;
#(
    parameter int IDX_W    = 6,
    parameter int STOP_IDX = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_rst,
    input  logic             cmd_start,
    input  logic [1:0]       cmd_kind,
    input  logic [IDX_W-1:0] cmd_index,
    input  logic             data_done,
    input  logic             rx_empty,
    input  logic             rx_full,
    input  logic             tx_empty,
    input  logic             tx_full,
    input  logic             cmd_complete,
    output logic             rx_active,
    output logic             tx_active,
    output logic             buf_empty,
    output logic             buf_full
);
    localparam logic [IDX_W-1:0] STOP_CODE = IDX_W'(STOP_IDX);

    logic     clr;
    cmd_evt_t ev;
    logic     rx_on, tx_on;

    assign clr      = rst | sw_rst;
    assign ev.start = cmd_start;
    assign ev.stop  = (cmd_index == STOP_CODE);
    assign ev.kind  = xfer_kind_e'(cmd_kind);

    rx_track u_rx (
        .clk       (clk),
        .clr       (clr),
        .ev        (ev),
        .data_done (data_done),
        .rx_empty  (rx_empty),
        .rx_on     (rx_on)
    );

    tx_track u_tx (
        .clk          (clk),
        .clr          (clr),
        .ev           (ev),
        .cmd_complete (cmd_complete),
        .tx_on        (tx_on)
    );

    bufstat_mux u_mux (
        .hold      (clr),
        .sel_rx    (rx_on),
        .rx_empty  (rx_empty),
        .rx_full   (rx_full),
        .tx_empty  (tx_empty),
        .tx_full   (tx_full),
        .buf_empty (buf_empty),
        .buf_full  (buf_full)
    );

    assign rx_active = rx_on & ~clr;
    assign tx_active = tx_on & ~clr;

    assert_exclusive_R9: assert property (@(posedge clk) disable iff (clr)
        !(rx_on && tx_on));

    assert_rst_idle_R1: assert property (@(posedge clk)
        rst |=> (!rx_on && !tx_on));

    assert_swrst_idle_R10: assert property (@(posedge clk)
        sw_rst |=> (!rx_on && !tx_on));

endmodule

// File: tb/sim_xfer_dir_tracker.sv
`timescale 1ns/1ps
module sim_xfer_dir_tracker;
    logic clk = 1'b0;
    logic rst, sw_rst, cmd_start, data_done, cmd_complete;
    logic [1:0] cmd_kind;
    logic [5:0] cmd_index;
    logic rx_empty, rx_full, tx_empty, tx_full;
    logic rx_active, tx_active, buf_empty, buf_full;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    xfer_dir_tracker u0 (
        .clk(clk), .rst(rst), .sw_rst(sw_rst), .cmd_start(cmd_start),
        .cmd_kind(cmd_kind), .cmd_index(cmd_index), .data_done(data_done),
        .rx_empty(rx_empty), .rx_full(rx_full), .tx_empty(tx_empty),
        .tx_full(tx_full), .cmd_complete(cmd_complete),
        .rx_active(rx_active), .tx_active(tx_active),
        .buf_empty(buf_empty), .buf_full(buf_full)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // drive one command pulse at a falling edge; sample at the next falling edge
    task automatic send_cmd(input logic [1:0] k, input logic [5:0] idx);
        cmd_start = 1'b1; cmd_kind = k; cmd_index = idx;
        @(negedge clk);
        cmd_start = 1'b0; cmd_kind = 2'b00; cmd_index = 6'd0;
    endtask

    task automatic pulse_done();
        data_done = 1'b1;
        @(negedge clk);
        data_done = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        idle(3);
        check("R1 rx_active in reset", rx_active, 1'b0);
        check("R1 tx_active in reset", tx_active, 1'b0);
        check("R1 buf_empty in reset", buf_empty, 1'b1);
        check("R1 buf_full in reset", buf_full, 1'b0);
        rst = 1'b0;
        idle(2);
        check("R1 rx_active after reset", rx_active, 1'b0);
        check("R1 tx_active after reset", tx_active, 1'b0);
    endtask

    task automatic t_single_read();
        rx_empty = 1'b0; rx_full = 1'b1; tx_empty = 1'b1; tx_full = 1'b0;
        send_cmd(2'b01, 6'd17);
        check("R2 rx_active after read start", rx_active, 1'b1);
        check("R5 buf_full follows rx", buf_full, 1'b1);
        check("R5 buf_empty follows rx", buf_empty, 1'b0);
        pulse_done();
        check("R3 held while buffer not drained", rx_active, 1'b1);
        idle(2);
        check("R3 still held", rx_active, 1'b1);
        rx_empty = 1'b1; rx_full = 1'b0;
        #1;
        check("R5 buf_empty tracks rx_empty at once", buf_empty, 1'b1);
        @(negedge clk);
        check("R3 cleared after drain", rx_active, 1'b0);
        tx_empty = 1'b0; tx_full = 1'b1;
        #1;
        check("R6 buf_full follows tx", buf_full, 1'b1);
        check("R6 buf_empty follows tx", buf_empty, 1'b0);
        tx_empty = 1'b1; tx_full = 1'b0;
        // done and empty in the same cycle
        rx_empty = 1'b0;
        send_cmd(2'b01, 6'd17);
        rx_empty = 1'b1;
        pulse_done();
        check("R3 cleared when done and empty coincide", rx_active, 1'b0);
    endtask

    task automatic t_multi_read();
        rx_empty = 1'b1; rx_full = 1'b0;
        send_cmd(2'b11, 6'd18);
        check("R4 rx_active after multi start", rx_active, 1'b1);
        pulse_done();
        check("R4 data_done ignored in multi", rx_active, 1'b1);
        send_cmd(2'b00, 6'd13);
        check("R4 non-data command ignored", rx_active, 1'b1);
        idle(3);
        check("R4 still held", rx_active, 1'b1);
        send_cmd(2'b00, 6'd12);
        check("R4 stop clears rx_active", rx_active, 1'b0);
    endtask

    task automatic t_write();
        rx_empty = 1'b0;
        send_cmd(2'b01, 6'd17);
        check("R2 read before write", rx_active, 1'b1);
        send_cmd(2'b10, 6'd24);
        check("R7 tx_active after write", tx_active, 1'b1);
        check("R7 write clears rx", rx_active, 1'b0);
        check("R9 not both high", rx_active & tx_active, 1'b0);
        idle(3);
        check("R7 tx_active held", tx_active, 1'b1);
        cmd_complete = 1'b1;
        @(negedge clk);
        cmd_complete = 1'b0;
        check("R8 complete drops tx", tx_active, 1'b0);
        rx_empty = 1'b1;
    endtask

    task automatic t_swrst();
        send_cmd(2'b10, 6'd25);
        check("R7 tx before sw reset", tx_active, 1'b1);
        tx_empty = 1'b0;
        sw_rst = 1'b1;
        #1;
        check("R10 tx masked same cycle", tx_active, 1'b0);
        check("R10 buf_empty forced", buf_empty, 1'b1);
        @(negedge clk);
        sw_rst = 1'b0;
        idle(1);
        check("R10 tx stays cleared", tx_active, 1'b0);
        check("R10 rx stays cleared", rx_active, 1'b0);
        tx_empty = 1'b1;
    endtask

    initial begin
        rst = 1'b1; sw_rst = 1'b0; cmd_start = 1'b0; cmd_kind = 2'b00;
        cmd_index = 6'd0; data_done = 1'b0; cmd_complete = 1'b0;
        rx_empty = 1'b1; rx_full = 1'b0; tx_empty = 1'b1; tx_full = 1'b0;
        fork
            begin
                @(negedge clk);
                t_reset();
                t_single_read();
                t_multi_read();
                t_write();
                t_swrst();
            end
            begin
                repeat (5000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule